// File: doc/BRIEF.md
# Grouped Non-Overlap Pulse Output Controller

This block drives a 16-pin pulse output port organised as four groups of four pins. Each group loads new pin values from a shared next-data register when a compare-match strobe arrives from the timer channel assigned to it. The timer, the choice of channel and the pin multiplexing sit outside the block. The block sees only two single-cycle strobes per group, called A and B.

A mode register selects, for each group, one of two modes. In ordinary mode the whole group copies its next-data nibble on strobe A. In non-overlap mode the falling and rising edges are split. Strobe B clears the pins whose next-data bit is 0. The following strobe A raises the pins whose bit is 1, using a copy of next data taken at B. Timer register B therefore sets the waveform period and timer register A sets the dead interval. During that interval no pin rises while a complementary pin is still falling.

Software reaches the mode register and the two next-data bytes through a small register bus. Writes are single-cycle and reads are combinational. A standby condition outside the block leaves the mode register unchanged, because only the reset clears it.

Top module: `nov_pulse_ctrl`

## Requirements
- R1: After reset the mode register reads 0xF0, both next-data bytes read 0x00 and pulse_o is 0x0000.
- R2: At address 0 (mode), write bits 3..0 are stored and read back, while read bits 7..4 are always 1 and ignore writes.
- R3: Address 1 reads and writes next-data bits 7..0 (groups 1 and 0), and address 2 reads and writes bits 15..8 (groups 3 and 2). Address 3 reads 0, and bus writes never change pulse_o directly.
- R4: Group g drives pulse_o[4g+3:4g], responds only to cma_i[g] and cmb_i[g], and is set to non-overlap mode by mode bit g.
- R5: With mode bit g at 0 (ordinary), cma_i[g] loads the group's next-data nibble into its pins on the next cycle, and cmb_i[g] alone has no effect.
- R6: With mode bit g at 1 (non-overlap), cmb_i[g] alone drives to 0 every pin of the group whose next-data bit is 0 and leaves the other pins unchanged, so no pin rises.
- R7: With mode bit g at 1, cma_i[g] alone drives to 1 every pin whose bit in the copy latched at the last cmb_i[g] is 1, and no pin falls. The copy resets to 0.
- R8: Next-data writes made between cmb_i[g] and the following cma_i[g] do not affect what that cma_i[g] applies.
- R9: With mode bit g at 1, cma_i[g] and cmb_i[g] in the same cycle apply B's clears first and then A's sets from the freshly sampled data, so the group ends equal to next data.
- R10: With neither strobe of a group active, that group's pins hold their value, even across mode or next-data writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address: 0 mode, 1 next-data low byte, 2 next-data high byte |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Combinational read data for bus_addr_i |
| cma_i | input | 4 | Compare-match A strobe, one bit per group |
| cmb_i | input | 4 | Compare-match B strobe, one bit per group |
| pulse_o | output | 16 | Pulse output pins |

## Verification
In ordinary mode the outputs are loaded with next-data patterns that mix ones and zeros, which shows whether each group copies exactly its own nibble on A and whether B leaves the pins alone. In non-overlap mode the data starts from an output that has both pins to clear and pins to set. That start shows whether B only clears and A only sets. Rewriting next data between B and A shows whether A uses the latched copy. Mixed mode settings with strobes on all groups together, simultaneous A and B strobes, and idle cycles with register writes separate the groups from each other and confirm the same-cycle ordering and the hold behaviour.

// File: rtl/nov_pkg.sv
package nov_pkg;
  localparam int unsigned BUS_W = 8;
  localparam logic [BUS_W-1:0] MODE_RD_FILL = 8'hFF;

  typedef enum logic [1:0] {
    ADR_MODE  = 2'd0,
    ADR_ND_LO = 2'd1,
    ADR_ND_HI = 2'd2
  } nov_addr_e;
endpackage

// File: rtl/nov_regs.sv
module nov_regs
  import nov_pkg::*;
#(
  parameter int unsigned N_GRP  = 4,
  parameter int unsigned PIN_W  = 16,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic [N_GRP-1:0]  mode_o,
  output logic [PIN_W-1:0]  nd_o
);
  localparam int unsigned N_BYTE = PIN_W / BUS_W;

  logic [N_GRP-1:0] mode_q;
  logic [PIN_W-1:0] nd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      mode_q <= '0;
    else if (we_i && addr_i == ADDR_W'(0))
      mode_q <= wdata_i[N_GRP-1:0];
  end

  for (genvar b = 0; b < N_BYTE; b++) begin : g_nd_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        nd_q[b*BUS_W +: BUS_W] <= '0;
      else if (we_i && addr_i == ADDR_W'(b + 1))
        nd_q[b*BUS_W +: BUS_W] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(0)) begin
      rdata_o = MODE_RD_FILL;
      rdata_o[N_GRP-1:0] = mode_q;
    end
    for (int b = 0; b < N_BYTE; b++) begin
      if (addr_i == ADDR_W'(b + 1))
        rdata_o = nd_q[b*BUS_W +: BUS_W];
    end
  end

  assign mode_o = mode_q;
  assign nd_o   = nd_q;
endmodule

// File: rtl/nov_group.sv
module nov_group #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         nov_i,
  input  logic         cma_i,
  input  logic         cmb_i,
  input  logic [W-1:0] nd_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, q_d;
  logic [W-1:0] lat_q, lat_d;
  logic [W-1:0] after_b, set_src;

  always_comb begin
    q_d     = q_q;
    lat_d   = lat_q;
    after_b = cmb_i ? (q_q & nd_i) : q_q;
    // same-cycle A uses the copy sampled by this B
    set_src = cmb_i ? nd_i : lat_q;
    if (nov_i) begin
      if (cmb_i) lat_d = nd_i;
      q_d = cma_i ? (after_b | set_src) : after_b;
    end else if (cma_i) begin
      q_d = nd_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q   <= '0;
      lat_q <= '0;
    end else begin
      q_q   <= q_d;
      lat_q <= lat_d;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/nov_pulse_ctrl.sv
module nov_pulse_ctrl
  import nov_pkg::*;
#(
  parameter int unsigned N_GRP = 4,
  parameter int unsigned GRP_W = 4,
  localparam int unsigned PIN_W  = N_GRP * GRP_W,
  localparam int unsigned ADDR_W = $clog2(PIN_W / BUS_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  input  logic [N_GRP-1:0]  cma_i,
  input  logic [N_GRP-1:0]  cmb_i,
  output logic [PIN_W-1:0]  pulse_o
);
  logic [N_GRP-1:0] mode_w;
  logic [PIN_W-1:0] nd_w;

  nov_regs #(
    .N_GRP (N_GRP),
    .PIN_W (PIN_W),
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (bus_we_i),
    .addr_i (bus_addr_i),
    .wdata_i(bus_wdata_i),
    .rdata_o(bus_rdata_o),
    .mode_o (mode_w),
    .nd_o   (nd_w)
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    nov_group #(.W(GRP_W)) u_grp (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .nov_i (mode_w[g]),
      .cma_i (cma_i[g]),
      .cmb_i (cmb_i[g]),
      .nd_i  (nd_w[g*GRP_W +: GRP_W]),
      .q_o   (pulse_o[g*GRP_W +: GRP_W])
    );
  end
endmodule

// File: rtl/nov_pulse_chk.sv
module nov_pulse_chk #(
  parameter int unsigned N_GRP  = 4,
  parameter int unsigned GRP_W  = 4,
  parameter int unsigned ADDR_W = 2
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [ADDR_W-1:0]      bus_addr_i,
  input logic [7:0]             bus_rdata_o,
  input logic [N_GRP-1:0]       cma_i,
  input logic [N_GRP-1:0]       cmb_i,
  input logic [N_GRP-1:0]       mode_w,
  input logic [N_GRP*GRP_W-1:0] nd_w,
  input logic [N_GRP*GRP_W-1:0] pulse_o
);
  p_mode_fill_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == ADDR_W'(0)) |-> (bus_rdata_o[7:N_GRP] == '1));

  for (genvar g = 0; g < N_GRP; g++) begin : g_chk
    p_ord_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mode_w[g] && cma_i[g]) |=>
        (pulse_o[g*GRP_W +: GRP_W] == $past(nd_w[g*GRP_W +: GRP_W])));

    p_ord_ignore_b_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mode_w[g] && !cma_i[g]) |=> $stable(pulse_o[g*GRP_W +: GRP_W]));

    p_nov_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_w[g] && cmb_i[g] && !cma_i[g]) |=>
        (pulse_o[g*GRP_W +: GRP_W] ==
         ($past(pulse_o[g*GRP_W +: GRP_W]) & $past(nd_w[g*GRP_W +: GRP_W]))));

    p_nov_rise_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_w[g] && cma_i[g] && !cmb_i[g]) |=>
        (($past(pulse_o[g*GRP_W +: GRP_W]) & ~pulse_o[g*GRP_W +: GRP_W]) == '0));

    p_nov_both_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_w[g] && cma_i[g] && cmb_i[g]) |=>
        (pulse_o[g*GRP_W +: GRP_W] == $past(nd_w[g*GRP_W +: GRP_W])));

    p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cma_i[g] && !cmb_i[g]) |=> $stable(pulse_o[g*GRP_W +: GRP_W]));
  end
endmodule

bind nov_pulse_ctrl nov_pulse_chk #(
  .N_GRP (N_GRP),
  .GRP_W (GRP_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_addr_i (bus_addr_i),
  .bus_rdata_o(bus_rdata_o),
  .cma_i      (cma_i),
  .cmb_i      (cmb_i),
  .mode_w     (mode_w),
  .nd_w       (nd_w),
  .pulse_o    (pulse_o)
);

// File: tb/nov_pulse_ctrl_tb.sv
module nov_pulse_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [1:0]  bus_addr_i = '0;
  logic [7:0]  bus_wdata_i = '0;
  logic [7:0]  bus_rdata_o;
  logic [3:0]  cma_i = '0;
  logic [3:0]  cmb_i = '0;
  logic [15:0] pulse_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  nov_pulse_ctrl u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_we_i   (bus_we_i),
    .bus_addr_i (bus_addr_i),
    .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o),
    .cma_i      (cma_i),
    .cmb_i      (cmb_i),
    .pulse_o    (pulse_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [1:0] a, input logic [7:0] exp);
    @(negedge clk_i);
    bus_addr_i = a;
    #1;
    check(req, {8'h00, bus_rdata_o}, {8'h00, exp});
  endtask

  // strobe for one cycle, result visible at the following negedge
  task automatic strobe(input logic [3:0] a, input logic [3:0] b);
    @(negedge clk_i);
    cma_i = a; cmb_i = b;
    @(negedge clk_i);
    cma_i = '0; cmb_i = '0;
  endtask

  task automatic set_nd(input logic [15:0] v);
    wr(2'd1, v[7:0]);
    wr(2'd2, v[15:8]);
  endtask

  task automatic t_reset();
    rd_check("R1 mode reset", 2'd0, 8'hF0);
    rd_check("R1 nd lo reset", 2'd1, 8'h00);
    rd_check("R1 nd hi reset", 2'd2, 8'h00);
    check("R1 pulse reset", pulse_o, 16'h0000);
  endtask

  task automatic t_mode_reg();
    wr(2'd0, 8'h0A);
    rd_check("R2 mode low bits", 2'd0, 8'hFA);
    wr(2'd0, 8'h05);
    rd_check("R2 upper bits fixed", 2'd0, 8'hF5);
    wr(2'd0, 8'h00);
    rd_check("R2 mode cleared", 2'd0, 8'hF0);
  endtask

  task automatic t_nd_reg();
    set_nd(16'hC35A);
    rd_check("R3 nd lo", 2'd1, 8'h5A);
    rd_check("R3 nd hi", 2'd2, 8'hC3);
    rd_check("R3 addr3 zero", 2'd3, 8'h00);
    check("R3 write no pin effect", pulse_o, 16'h0000);
  endtask

  task automatic t_ordinary();
    strobe(4'hF, 4'h0);
    check("R5 ordinary load on A", pulse_o, 16'hC35A);
    set_nd(16'h0000);
    strobe(4'h0, 4'hF);
    check("R5 ordinary ignores B", pulse_o, 16'hC35A);
    set_nd(16'hFFFF);
    strobe(4'b0010, 4'h0);
    check("R4 only group 1 loads", pulse_o, 16'hC3FA);
  endtask

  task automatic t_nonoverlap();
    set_nd(16'h0F0F);
    strobe(4'hF, 4'h0);
    check("R5 preset", pulse_o, 16'h0F0F);
    wr(2'd0, 8'h0F);
    set_nd(16'h00FF);
    strobe(4'h0, 4'hF);
    check("R6 B clears only", pulse_o, 16'h000F);
    set_nd(16'h0000);
    strobe(4'hF, 4'h0);
    check("R7 R8 A sets from latched copy", pulse_o, 16'h00FF);
    set_nd(16'hFFFF);
    strobe(4'h0, 4'hF);
    check("R6 B never raises", pulse_o, 16'h00FF);
    set_nd(16'h0000);
    strobe(4'hF, 4'h0);
    check("R7 A never lowers", pulse_o, 16'hFFFF);
  endtask

  task automatic t_mixed();
    // latched copies: all groups 0xF from last B
    set_nd(16'h00FF);
    strobe(4'h0, 4'hF);
    check("R6 clear groups 3,2", pulse_o, 16'h00FF);
    wr(2'd0, 8'h05);
    set_nd(16'hF0F0);
    strobe(4'hF, 4'h0);
    // groups 3,1 ordinary -> F,F ; groups 2,0 nov OR latched 0,F
    check("R4 mixed modes", pulse_o, 16'hF0FF);
  endtask

  task automatic t_same_cycle();
    wr(2'd0, 8'h0F);
    set_nd(16'h3C3C);
    strobe(4'hF, 4'hF);
    check("R9 A+B same cycle", pulse_o, 16'h3C3C);
    set_nd(16'hA5A5);
    strobe(4'b0001, 4'b0001);
    check("R9 R4 group 0 only", pulse_o, 16'h3C35);
  endtask

  task automatic t_hold();
    wr(2'd0, 8'h00);
    set_nd(16'h1234);
    repeat (4) @(negedge clk_i);
    check("R10 idle hold", pulse_o, 16'h3C35);
    strobe(4'h0, 4'h0);
    check("R10 hold after writes", pulse_o, 16'h3C35);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_mode_reg();
    t_nd_reg();
    t_ordinary();
    t_nonoverlap();
    t_mixed();
    t_same_cycle();
    t_hold();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule